// File: doc/BRIEF.md
# Scatter-Gather Bus-Master DMA Engine for a Disk Channel

This block is the host-side DMA mover for one disk channel. Software writes a 32-bit pointer to a table of 8-byte physical region entries, picks a direction and sets a go bit. The engine then reads the table entry by entry through a simple memory request port. It moves 16-bit words between that memory and the device's word stream, to consecutive memory addresses, until either the device marks its final word or the table runs out.

The way a transfer ends is reported through two status flags, `Active` and `Interrupt`. A table that covers exactly the device's transfer length ends with `Interrupt` set and `Active` clear. A table that is larger ends with both flags set, and the engine parks until software stops it. A table that is too short ends with both flags clear. Software stops a transfer by clearing the go bit.

Top module: `bmdma_prd_engine`

## Requirements
- R1: The register port is byte addressed. Command is at offset 0: bit 0 is go and bit 3 is direction. Status is at offset 2: bit 0 is Active, bit 1 is Error and bit 2 is Interrupt. The table pointer is at offset 4, and its bits 1:0 read as zero. A command write that sets go while go was clear sets Active. The engine then reads table entries in order, starting at the pointer. Each entry is two little-endian 32-bit reads: first the buffer address, then a control word whose bits 15:0 are the byte count and whose bit 31 marks the final entry.
- R2: With direction 1, device words are written to memory. With direction 0, memory words are sent to the device. Each entry's buffer is filled or drained as 16-bit words at byte addresses that step by 2, and the next entry's buffer follows in table order.
- R3: Bit 0 of a byte count is ignored, and a byte count of zero describes 65536 bytes.
- R4: If the device's final word also ends the final entry, Interrupt is set and Active is cleared.
- R5: If the device's final word arrives while table space remains, Interrupt is set, Active stays set and no further memory or device transfers occur.
- R6: If the final entry is used up before the device's final word, Active is cleared and Interrupt stays clear.
- R7: A command write with go clear stops the engine at once and clears Active. It leaves Interrupt unchanged.
- R8: Writing 1 to status bit 2 or bit 1 clears that bit. The `irq` output follows Interrupt.
- R9: Writes to the table pointer are ignored while Active is set.
- R10: A memory response with the error flag sets Error and clears Active.
- R11: After reset, every register reads zero, `irq` is low and no request is raised.
- R12: At most one of `mem_req`, `dev_in_ready` and `dev_out_valid` is high at a time. A memory request holds its address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | Memory access is a write |
| mem_wide | output | 1 | 32-bit table read (otherwise 16-bit data access in the low half) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (data word in bits 15:0) |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data |
| mem_err | input | 1 | Memory access failed, valid with ack |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_ready | output | 1 | Engine takes the offered word |
| dev_in_data | input | 16 | Word from device |
| dev_out_valid | output | 1 | Engine offers a word to the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| dev_out_data | output | 16 | Word to device |
| dev_last | input | 1 | The word handshaken this cycle is the device's final word |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the three ways a transfer can end and the boundaries between them. It uses a table that is exactly full across two entries, one with space left in a second entry, and short tables in both directions. A design that mixed these up would report the wrong Active/Interrupt pair, or would keep moving data into memory past the device's final word. That extra data is caught by a guard word that must stay zero. Odd and zero byte counts check the count decoding; getting it wrong shifts the point where the transfer ends. The bench also stops a parked transfer, writes the pointer while Active is set, and injects a memory error on a table read. A design that got these wrong would leave Active set, lose or corrupt the pointer, or hang waiting on memory.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int REG_W     = 32;
    localparam int MEM_W     = 32;
    localparam int PRD_CNT_W = 17;

    localparam logic [2:0] REG_CMD = 3'd0;
    localparam logic [2:0] REG_STS = 3'd2;
    localparam logic [2:0] REG_PTR = 3'd4;

    localparam int CMD_GO_BIT    = 0;
    localparam int CMD_TOMEM_BIT = 3;
    localparam int STS_ACT_BIT   = 0;
    localparam int STS_ERR_BIT   = 1;
    localparam int STS_INT_BIT   = 2;
    localparam int DESC_END_BIT  = 31;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DESC_A,
        S_DESC_B,
        S_DEV_GET,
        S_MEM_WR,
        S_MEM_RD,
        S_DEV_PUT,
        S_HOLD
    } eng_state_e;

    typedef struct packed {
        logic intr;
        logic err;
        logic active;
    } sts_t;

    // Byte count field: bit 0 dropped, zero means the full 64 KiB
    function automatic logic [PRD_CNT_W-1:0] prd_bytes(input logic [15:0] field);
        logic [15:0] even;
        even = {field[15:1], 1'b0};
        return (even == 16'd0) ? PRD_CNT_W'(17'h10000) : PRD_CNT_W'(even);
    endfunction

endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             eng_done,
    input  logic             eng_int,
    input  logic             eng_err,
    output logic             go_pulse,
    output logic             stop_pulse,
    output logic             to_mem,
    output logic [AW-1:0]    tbl_ptr,
    output sts_t             sts
);

    logic cmd_go;
    logic cmd_wr, sts_wr, ptr_wr;

    assign cmd_wr     = reg_wr && (reg_addr == REG_CMD);
    assign sts_wr     = reg_wr && (reg_addr == REG_STS);
    assign ptr_wr     = reg_wr && (reg_addr == REG_PTR);
    assign go_pulse   = cmd_wr && reg_wdata[CMD_GO_BIT] && !cmd_go;
    assign stop_pulse = cmd_wr && !reg_wdata[CMD_GO_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_go  <= 1'b0;
            to_mem  <= 1'b0;
            tbl_ptr <= '0;
            sts     <= '0;
        end else begin
            if (cmd_wr) begin
                cmd_go <= reg_wdata[CMD_GO_BIT];
                if (!sts.active || stop_pulse)
                    to_mem <= reg_wdata[CMD_TOMEM_BIT];
            end
            if (ptr_wr && !sts.active)
                tbl_ptr <= {reg_wdata[AW-1:2], 2'b00};

            if (go_pulse)
                sts.active <= 1'b1;
            else if (stop_pulse || eng_done || eng_err)
                sts.active <= 1'b0;

            if (eng_int)
                sts.intr <= 1'b1;
            else if (sts_wr && reg_wdata[STS_INT_BIT])
                sts.intr <= 1'b0;

            if (eng_err)
                sts.err <= 1'b1;
            else if (sts_wr && reg_wdata[STS_ERR_BIT])
                sts.err <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_CMD: reg_rdata = REG_W'({to_mem, 2'b00, cmd_go});
            REG_STS: reg_rdata = REG_W'(sts);
            REG_PTR: reg_rdata = REG_W'(tbl_ptr);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
    import bmdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go_pulse,
    input  logic             stop_pulse,
    input  logic             to_mem,
    input  logic [AW-1:0]    tbl_ptr,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [AW-1:0]    mem_addr,
    output logic [MEM_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [MEM_W-1:0] mem_rdata,
    input  logic             mem_err,
    input  logic             dev_in_valid,
    output logic             dev_in_ready,
    input  logic [DW-1:0]    dev_in_data,
    output logic             dev_out_valid,
    input  logic             dev_out_ready,
    output logic [DW-1:0]    dev_out_data,
    input  logic             dev_last,
    output logic             eng_done,
    output logic             eng_int,
    output logic             eng_err
);

    localparam int STEP = DW / 8;

    eng_state_e           state, state_nx;
    logic [AW-1:0]        desc_ptr, buf_addr;
    logic [PRD_CNT_W-1:0] remain, remain_nx;
    logic                 end_ent, last_q;
    logic [DW-1:0]        word;
    logic                 beat, beat_last, mem_fail;

    assign mem_req       = (state == S_DESC_A) || (state == S_DESC_B) ||
                           (state == S_MEM_WR) || (state == S_MEM_RD);
    assign mem_we        = (state == S_MEM_WR);
    assign mem_wide      = (state == S_DESC_A) || (state == S_DESC_B);
    assign mem_addr      = (state == S_DESC_A) ? desc_ptr :
                           (state == S_DESC_B) ? desc_ptr + AW'(4) : buf_addr;
    assign mem_wdata     = MEM_W'(word);
    assign dev_in_ready  = (state == S_DEV_GET);
    assign dev_out_valid = (state == S_DEV_PUT);
    assign dev_out_data  = word;

    assign mem_fail  = mem_req && mem_ack && mem_err;
    assign beat      = ((state == S_MEM_WR) && mem_ack && !mem_err) ||
                       ((state == S_DEV_PUT) && dev_out_ready);
    assign beat_last = (state == S_MEM_WR) ? last_q : dev_last;
    assign remain_nx = remain - PRD_CNT_W'(STEP);

    always_comb begin
        state_nx = state;
        eng_done = 1'b0;
        eng_int  = 1'b0;
        eng_err  = 1'b0;
        if (stop_pulse) begin
            state_nx = S_IDLE;
        end else if (go_pulse) begin
            state_nx = S_DESC_A;
        end else if (mem_fail) begin
            eng_err  = 1'b1;
            state_nx = S_IDLE;
        end else if (beat) begin
            if (beat_last) begin
                eng_int  = 1'b1;
                eng_done = (remain_nx == '0) && end_ent;
                state_nx = eng_done ? S_IDLE : S_HOLD;
            end else if (remain_nx == '0) begin
                eng_done = end_ent;
                state_nx = end_ent ? S_IDLE : S_DESC_A;
            end else begin
                state_nx = to_mem ? S_DEV_GET : S_MEM_RD;
            end
        end else begin
            unique case (state)
                S_DESC_A:  if (mem_ack) state_nx = S_DESC_B;
                S_DESC_B:  if (mem_ack) state_nx = to_mem ? S_DEV_GET : S_MEM_RD;
                S_DEV_GET: if (dev_in_valid) state_nx = S_MEM_WR;
                S_MEM_RD:  if (mem_ack) state_nx = S_DEV_PUT;
                default:   state_nx = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            desc_ptr <= '0;
            buf_addr <= '0;
            remain   <= '0;
            end_ent  <= 1'b0;
            last_q   <= 1'b0;
            word     <= '0;
        end else begin
            state <= state_nx;
            if (go_pulse)
                desc_ptr <= tbl_ptr;
            if (mem_ack && !mem_err && !stop_pulse) begin
                if (state == S_DESC_A)
                    buf_addr <= mem_rdata[AW-1:0];
                if (state == S_DESC_B) begin
                    remain   <= prd_bytes(mem_rdata[15:0]);
                    end_ent  <= mem_rdata[DESC_END_BIT];
                    desc_ptr <= desc_ptr + AW'(8);
                end
                if (state == S_MEM_RD)
                    word <= mem_rdata[DW-1:0];
            end
            if ((state == S_DEV_GET) && dev_in_valid) begin
                word   <= dev_in_data;
                last_q <= dev_last;
            end
            if (beat) begin
                remain   <= remain_nx;
                buf_addr <= buf_addr + AW'(STEP);
            end
        end
    end

endmodule

// File: rtl/bmdma_prd_engine.sv
module bmdma_prd_engine
    import bmdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [AW-1:0]    mem_addr,
    output logic [MEM_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [MEM_W-1:0] mem_rdata,
    input  logic             mem_err,
    input  logic             dev_in_valid,
    output logic             dev_in_ready,
    input  logic [DW-1:0]    dev_in_data,
    output logic             dev_out_valid,
    input  logic             dev_out_ready,
    output logic [DW-1:0]    dev_out_data,
    input  logic             dev_last,
    output logic             irq
);

    logic          go_pulse, stop_pulse, to_mem;
    logic          eng_done, eng_int, eng_err;
    logic [AW-1:0] tbl_ptr;
    sts_t          sts;
    logic          sts_active, sts_err;

    assign sts_active = sts.active;
    assign sts_err    = sts.err;
    assign irq        = sts.intr;

    bmdma_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .eng_done   (eng_done),
        .eng_int    (eng_int),
        .eng_err    (eng_err),
        .go_pulse   (go_pulse),
        .stop_pulse (stop_pulse),
        .to_mem     (to_mem),
        .tbl_ptr    (tbl_ptr),
        .sts        (sts)
    );

    bmdma_engine #(.AW(AW), .DW(DW)) u_engine (
        .clk           (clk),
        .rst           (rst),
        .go_pulse      (go_pulse),
        .stop_pulse    (stop_pulse),
        .to_mem        (to_mem),
        .tbl_ptr       (tbl_ptr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_wide      (mem_wide),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .mem_err       (mem_err),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data),
        .dev_last      (dev_last),
        .eng_done      (eng_done),
        .eng_int       (eng_int),
        .eng_err       (eng_err)
    );

endmodule

// File: rtl/bmdma_prd_engine_chk.sv
module bmdma_prd_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [AW-1:0] mem_addr,
    input logic          dev_in_ready,
    input logic          dev_out_valid,
    input logic          active,
    input logic          err_bit,
    input logic          irq,
    input logic [AW-1:0] tbl_ptr
);

    logic stop_wr;
    assign stop_wr = reg_wr && (reg_addr == 3'd0) && !reg_wdata[0];

    // R7
    abort_halts_chk: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> !active && !mem_req && !dev_in_ready && !dev_out_valid);

    // R9
    ptr_locked_chk: assert property (@(posedge clk) disable iff (rst)
        active && reg_wr && (reg_addr == 3'd4) |=> $stable(tbl_ptr));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack && !stop_wr |=> mem_req && $stable(mem_addr));

    // R12
    one_activity_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req, dev_in_ready, dev_out_valid}));

    // R10
    mem_fault_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && mem_err && !stop_wr |=> err_bit && !active);

    // R8
    int_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr && (reg_addr == 3'd2) && reg_wdata[2] && !active |=> !irq);

endmodule

bind bmdma_prd_engine bmdma_prd_engine_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .mem_req       (mem_req),
    .mem_ack       (mem_ack),
    .mem_err       (mem_err),
    .mem_addr      (mem_addr),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .active        (sts_active),
    .err_bit       (sts_err),
    .irq           (irq),
    .tbl_ptr       (tbl_ptr)
);

// File: tb/bmdma_prd_engine_test.sv
module bmdma_prd_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_wide;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        dev_in_valid = 1'b0;
    logic        dev_in_ready;
    logic [15:0] dev_in_data = '0;
    logic        dev_out_valid;
    logic        dev_out_ready = 1'b0;
    logic [15:0] dev_out_data;
    logic        dev_last = 1'b0;
    logic        irq;

    always #10 clk = ~clk;

    bmdma_prd_engine uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
        .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
        .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
        .dev_last(dev_last), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: 1024 halfwords, byte address bits 10:1
    logic [15:0] mem [0:1023];
    bit          err_on = 1'b0;
    logic [31:0] err_addr = '0;

    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   = 1'b1;
            mem_rdata = {mem[10'(mem_addr[10:1] + 10'd1)], mem[mem_addr[10:1]]};
            mem_err   = err_on && (mem_addr == err_addr);
        end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end
    end

    // Device model
    bit          dev_en = 1'b0;
    bit          dev_dir = 1'b0;
    int          d_len = 0, d_cnt = 0, o_cnt = 0, cur_v = 0, overlap = 0;
    logic [15:0] got [0:63];

    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we && !mem_err)
            mem[mem_addr[10:1]] = mem_wdata[15:0];
        if (dev_in_valid && dev_in_ready)
            d_cnt++;
        if (dev_out_valid && dev_out_ready) begin
            got[o_cnt[5:0]] = dev_out_data;
            o_cnt++;
        end
        if (!rst && (32'(mem_req) + 32'(dev_in_ready) + 32'(dev_out_valid) > 1))
            overlap++;
    end

    always @(negedge clk) begin
        if (dev_en && dev_dir) begin
            dev_in_valid  = (d_cnt < d_len);
            dev_in_data   = 16'(32'hC000 + cur_v * 256 + d_cnt);
            dev_last      = (d_cnt == d_len - 1);
            dev_out_ready = 1'b0;
        end else if (dev_en) begin
            dev_in_valid  = 1'b0;
            dev_out_ready = (o_cnt < d_len);
            dev_last      = (o_cnt == d_len - 1);
        end else begin
            dev_in_valid  = 1'b0;
            dev_out_ready = 1'b0;
            dev_last      = 1'b0;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    typedef struct packed {
        logic       to_mem;
        logic [1:0] n_ent;
        logic [15:0] s0;
        logic [15:0] s1;
        logic [7:0] words;
        logic [2:0] exp_sts;
        logic [2:0] exp_abort;
    } vec_t;

    // status encoding {Interrupt, Error, Active}
    localparam vec_t VECS [0:8] = '{
        '{1'b1, 2'd1, 16'd8,  16'd0, 8'd4, 3'd4, 3'd4},  // R4 exact, to memory
        '{1'b1, 2'd1, 16'd16, 16'd0, 8'd4, 3'd5, 3'd4},  // R5 oversize
        '{1'b1, 2'd1, 16'd6,  16'd0, 8'd4, 3'd0, 3'd0},  // R6 undersize
        '{1'b0, 2'd2, 16'd4,  16'd4, 8'd4, 3'd4, 3'd4},  // R4 exact over two entries
        '{1'b0, 2'd1, 16'd9,  16'd0, 8'd4, 3'd4, 3'd4},  // R3 odd count
        '{1'b1, 2'd1, 16'd0,  16'd0, 8'd4, 3'd5, 3'd4},  // R3 zero count = 64 KiB
        '{1'b0, 2'd2, 16'd4,  16'd8, 8'd4, 3'd5, 3'd4},  // R5 space left in 2nd entry
        '{1'b1, 2'd2, 16'd2,  16'd2, 8'd3, 3'd0, 3'd0},  // R6 short over two entries
        '{1'b0, 2'd1, 16'd3,  16'd0, 8'd2, 3'd0, 3'd0}   // R3/R6 odd short, from memory
    };

    function automatic int cap_w(input logic [15:0] s);
        int b = int'({s[15:1], 1'b0});
        return (b == 0) ? 32768 : b / 2;
    endfunction

    function automatic int loc(input vec_t v, input int k);
        int c0 = cap_w(v.s0);
        return (k < c0) ? 256 + k : 384 + (k - c0);
    endfunction

    task automatic run_case(input int vi);
        vec_t        v = VECS[vi];
        logic [31:0] st, ptr_rd;
        int          c0 = cap_w(v.s0);
        int          tot = c0 + ((v.n_ent == 2'd2) ? cap_w(v.s1) : 0);
        int          moved = (int'(v.words) < tot) ? int'(v.words) : tot;
        int          bad = 0;
        bit          done = 1'b0;
        reg_write(3'd0, 32'h0);
        reg_write(3'd2, 32'h6);
        mem[128] = 16'h0200; mem[129] = 16'h0000;
        mem[130] = v.s0;     mem[131] = (v.n_ent == 2'd1) ? 16'h8000 : 16'h0000;
        mem[132] = 16'h0300; mem[133] = 16'h0000;
        mem[134] = v.s1;     mem[135] = 16'h8000;
        for (int j = 0; j < 128; j++) mem[256 + j] = 16'h0;
        if (!v.to_mem)
            for (int k = 0; k < 16; k++) mem[loc(v, k)] = 16'(32'hA000 + vi * 256 + k);
        cur_v = vi; d_len = int'(v.words); d_cnt = 0; o_cnt = 0;
        dev_dir = v.to_mem; dev_en = 1'b1;
        reg_write(3'd4, 32'h100);
        reg_write(3'd0, v.to_mem ? 32'h9 : 32'h1);
        for (int t = 0; t < 2000 && !done; t++) begin
            @(negedge clk);
            reg_read(3'd2, st);
            if ((st & 32'h5) != 32'h1) done = 1'b1;
        end
        chk(done, "R1 transfer finishes", st, {29'b0, v.exp_sts});
        repeat (3) @(negedge clk);
        reg_read(3'd2, st);
        chk(st == {29'b0, v.exp_sts}, $sformatf("R4/R5/R6 end status v%0d", vi),
            st, {29'b0, v.exp_sts});
        for (int k = 0; k < moved; k++) begin
            if (v.to_mem && mem[loc(v, k)] != 16'(32'hC000 + vi * 256 + k)) bad++;
            if (!v.to_mem && got[k] != 16'(32'hA000 + vi * 256 + k)) bad++;
        end
        if (v.to_mem && moved < tot && mem[loc(v, moved)] != 16'h0) bad++;
        if (!v.to_mem && o_cnt != moved) bad++;
        chk(bad == 0, $sformatf("R1/R2 data v%0d", vi), 32'(bad), 32'd0);
        if (v.exp_sts[0]) begin
            reg_write(3'd4, 32'h3F0);
            reg_read(3'd4, ptr_rd);
            chk(ptr_rd == 32'h100, "R9 pointer locked while active", ptr_rd, 32'h100);
        end
        reg_write(3'd0, v.to_mem ? 32'h8 : 32'h0);
        reg_read(3'd2, st);
        chk(st == {29'b0, v.exp_abort}, $sformatf("R7 status after stop v%0d", vi),
            st, {29'b0, v.exp_abort});
        if (v.exp_abort[2])
            chk(irq == 1'b1, "R8 irq follows interrupt", 32'(irq), 32'd1);
        dev_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        reg_read(3'd0, rd); chk(rd == 0, "R11 command after reset", rd, 0);
        reg_read(3'd2, rd); chk(rd == 0, "R11 status after reset", rd, 0);
        reg_read(3'd4, rd); chk(rd == 0, "R11 pointer after reset", rd, 0);
        chk(!irq && !mem_req, "R11 irq and request idle", {30'b0, irq, mem_req}, 0);

        for (int vi = 0; vi < 9; vi++) run_case(vi);

        // R8 write-one-to-clear of Interrupt
        reg_write(3'd2, 32'h4);
        reg_read(3'd2, rd);
        chk(rd == 0 && !irq, "R8 interrupt cleared", rd, 0);

        // R10 memory error on the control word fetch
        reg_write(3'd0, 32'h0);
        err_on = 1'b1; err_addr = 32'h104;
        reg_write(3'd4, 32'h100);
        reg_write(3'd0, 32'h9);
        repeat (20) @(negedge clk);
        reg_read(3'd2, rd);
        chk(rd == 32'h2, "R10 error set, active cleared", rd, 32'h2);
        err_on = 1'b0;
        reg_write(3'd2, 32'h2);
        reg_read(3'd2, rd);
        chk(rd == 0, "R8 error cleared", rd, 0);

        // R1 pointer low bits read as zero
        reg_write(3'd0, 32'h0);
        reg_write(3'd4, 32'h123);
        reg_read(3'd4, rd);
        chk(rd == 32'h120, "R1 pointer alignment", rd, 32'h120);

        chk(overlap == 0, "R12 single activity", 32'(overlap), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule